// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block measures the speed of one fan. It counts a slow reference tick, nominally 8192 Hz and given as a one-cycle enable in the system clock domain, over a chosen number of whole tachometer periods. At the end of that window it captures the total as an 11-bit result. A long result means a slow fan. The result is roughly 60 × 8192 × SR / (NP × RPM), where SR is the number of periods measured and NP is the fan's pulses per revolution. RPM conversion is left to whatever reads the result.

The tachometer input is first synchronised to the system clock. It then passes a width filter, so that short noise spikes are not taken as edges. The glitch threshold is a port, given in system clocks, so the caller can set it to about 25 µs for its own clock. A window opens on a filtered rising edge and closes on the rising edge that completes the selected number of periods. That same edge opens the next window, so windows follow one another with no gap. The running tick count stops at 0x7FF and does not wrap. A flag shows when it has stopped there, and this flag also serves as an early sign that the fan has stalled.

Top module: `tach_period_meter`

## Requirements
- R1: After reset, tachCount is 0, countValid is 0 and countSat is 0.
- R2: For periodSel values 0 to 5 the window spans 2^periodSel tach periods. The latched count equals the number of refTick cycles after the opening edge, up to and including the closing edge.
- R3: periodSel values 6 and 7 both select a window of 32 periods.
- R4: countValid is high for exactly one cycle per completed window, the cycle after the closing edge. The closing edge opens the next window, so a steady tach gives one strobe every window length.
- R5: The running count stops at 2047 (0x7FF) and never wraps. A window that runs past 2047 ticks latches 2047.
- R6: countSat is high while the running count is held at 2047. With no tach edges it rises after 2047 ticks and no countValid is produced.
- R7: A tach high pulse that lasts fewer system clocks than glitchLimit is ignored. It neither opens, advances nor closes a window.
- R8: A change of periodSel abandons the window in progress without a countValid. Measurement restarts on the next filtered rising edge.
- R9: tachCount holds its value in every cycle in which countValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle enable at the reference rate |
| tachIn | input | 1 | Raw tachometer input, asynchronous |
| periodSel | input | 3 | Window length select, 2^n periods (6 and 7 mean 32) |
| glitchLimit | input | 16 | Minimum accepted pulse width, in system clocks |
| tachCount | output | 11 | Latched tick count of the last completed window |
| countValid | output | 1 | One-cycle strobe when tachCount is updated |
| countSat | output | 1 | Running count is held at its 2047 ceiling |

## Verification
The bench sends steady tach trains at every select value, including the two out-of-range codes, and checks that every latched count equals period × SR exactly. A window that is one period off, or an off-by-one where the opening tick is counted, shows up as a wrong value. A long window that crosses 2047 checks the ceiling: a counter that wraps would latch a small value. Narrow spikes placed inside the low phase would, without working filtering, open extra windows and give short counts. A select change halfway through a window checks the abort: a design that ignores the change either produces a strobe from the stale window or never produces one. A silent tach line checks that countSat rises near 2047 ticks and not before.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_LOG = 5;
  localparam int PER_W   = MAX_LOG + 1;

  typedef struct packed {
    logic clearCnt;
    logic latchCnt;
  } tpm_strobe_t;

  function automatic logic [PER_W-1:0] periodTarget(input logic [SEL_W-1:0] sel);
    logic [PER_W-1:0] one;
    one = PER_W'(1);
    if (sel > SEL_W'(MAX_LOG)) return one << MAX_LOG;
    return one << sel;
  endfunction
endpackage

// File: rtl/tpm_edge_filter.sv
module tpm_edge_filter #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tachIn,
  input  logic [LIMIT_W-1:0] glitchLimit,
  output logic               qualRise
);
  logic               syncA, syncB;
  logic               filtLvl;
  logic [LIMIT_W-1:0] runCnt;
  logic               differ, reached, flip;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= tachIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    differ   = (syncB != filtLvl);
    reached  = ({1'b0, runCnt} + (LIMIT_W+1)'(1)) >= {1'b0, glitchLimit};
    flip     = differ && reached;
    qualRise = flip && syncB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      runCnt  <= '0;
    end else if (!differ) begin
      runCnt <= '0;
    end else if (flip) begin
      runCnt  <= '0;
      filtLvl <= syncB;
    end else if (runCnt != '1) begin
      runCnt <= runCnt + LIMIT_W'(1);
    end
  end

  AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLvl) |-> filtLvl == $past(syncB)); // R7
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             qualRise,
  input  logic [SEL_W-1:0] periodSel,
  output tpm_strobe_t      strobes
);
  logic [SEL_W-1:0] prevSel;
  logic             armed;
  logic [PER_W-1:0] periodsDone;
  logic [PER_W-1:0] target;
  logic             selChanged, lastPeriod;

  always_comb begin
    selChanged = (periodSel != prevSel);
    target     = periodTarget(periodSel);
    lastPeriod = (periodsDone + PER_W'(1)) == target;
    strobes    = '0;
    if (selChanged) begin
      strobes.clearCnt = 1'b1;
    end else if (qualRise) begin
      if (!armed) begin
        strobes.clearCnt = 1'b1;
      end else if (lastPeriod) begin
        strobes.clearCnt = 1'b1;
        strobes.latchCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel     <= '0;
      armed       <= 1'b0;
      periodsDone <= '0;
    end else begin
      prevSel <= periodSel;
      if (selChanged) begin
        armed       <= 1'b0;
        periodsDone <= '0;
      end else if (qualRise) begin
        armed <= 1'b1;
        if (!armed || lastPeriod) periodsDone <= '0;
        else                      periodsDone <= periodsDone + PER_W'(1);
      end
    end
  end

  AST_ABORT_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel != prevSel) |-> !strobes.latchCnt); // R8
  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    periodsDone < periodTarget(prevSel) || !armed); // R2
  AST_LATCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchCnt |-> armed && qualRise); // R4
endmodule

// File: rtl/tpm_datapath.sv
module tpm_datapath
  import tpm_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  tpm_strobe_t      strobes,
  output logic [CNT_W-1:0] tachCount,
  output logic             countValid,
  output logic             countSat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] runCnt, cntNext;

  always_comb begin
    cntNext  = (refTick && runCnt != CNT_MAX) ? runCnt + CNT_W'(1) : runCnt;
    countSat = (runCnt == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt     <= '0;
      tachCount  <= '0;
      countValid <= 1'b0;
    end else begin
      countValid <= strobes.latchCnt;
      if (strobes.latchCnt) tachCount <= cntNext;
      runCnt <= strobes.clearCnt ? '0 : cntNext;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt == CNT_MAX && !strobes.clearCnt) |=> runCnt == CNT_MAX); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    countValid |=> !countValid); // R4
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !countValid |-> $stable(tachCount)); // R9
endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter
  import tpm_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               tachIn,
  input  logic [SEL_W-1:0]   periodSel,
  input  logic [LIMIT_W-1:0] glitchLimit,
  output logic [CNT_W-1:0]   tachCount,
  output logic               countValid,
  output logic               countSat
);
  logic        qualRise;
  tpm_strobe_t strobes;

  tpm_edge_filter #(.LIMIT_W(LIMIT_W)) uFilter (
    .clk(clk), .rstN(rstN), .tachIn(tachIn),
    .glitchLimit(glitchLimit), .qualRise(qualRise)
  );

  tpm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .qualRise(qualRise),
    .periodSel(periodSel), .strobes(strobes)
  );

  tpm_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .refTick(refTick), .strobes(strobes),
    .tachCount(tachCount), .countValid(countValid), .countSat(countSat)
  );
endmodule

// File: tb/tb_tach_period_meter.sv
module tb_tach_period_meter;
  localparam int TICK_N = 4;
  localparam int HIGH_CLK = 20;
  localparam int NVEC = 8;
  localparam int V_SEL [NVEC] = '{0, 1, 2, 3, 5, 7, 4, 6};
  localparam int V_PER [NVEC] = '{50, 40, 30, 20, 10, 8, 200, 16};
  localparam int V_EXP [NVEC] = '{50, 80, 120, 160, 320, 256, 2047, 512};

  logic clk = 1'b0, rstN = 1'b0, refTick = 1'b0, tachIn = 1'b0;
  logic [2:0] periodSel = 3'd0;
  logic [15:0] glitchLimit = 16'd8;
  logic [10:0] tachCount;
  logic countValid, countSat;

  int total = 0, bad = 0;
  int validsSeen = 0, latchBad = 0, lastCount = 0, expCur = 0;
  bit satSeen = 1'b0;
  int tickPhase = 0;

  always #2.5 clk = ~clk;

  tach_period_meter dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .tachIn(tachIn),
    .periodSel(periodSel), .glitchLimit(glitchLimit),
    .tachCount(tachCount), .countValid(countValid), .countSat(countSat)
  );

  always @(negedge clk) begin
    tickPhase = (tickPhase + 1) % TICK_N;
    refTick   = (tickPhase == 0);
    if (countSat) satSeen = 1'b1;
    if (countValid) begin
      validsSeen = validsSeen + 1;
      lastCount  = int'(tachCount);
      if (int'(tachCount) != expCur) latchBad = latchBad + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runTach(input int periodClk, input int n, input bit glitch);
    for (int i = 0; i < n; i++) begin
      tachIn = 1'b1;
      repeat (HIGH_CLK) @(negedge clk);
      tachIn = 1'b0;
      if (glitch) begin
        repeat (40) @(negedge clk);
        tachIn = 1'b1;
        repeat (3) @(negedge clk);
        tachIn = 1'b0;
        repeat (periodClk - HIGH_CLK - 43) @(negedge clk);
      end else begin
        repeat (periodClk - HIGH_CLK) @(negedge clk);
      end
    end
  endtask

  task automatic startRun(input int sel, input int exp);
    periodSel = 3'(sel);
    repeat (10) @(negedge clk);
    validsSeen = 0; latchBad = 0; lastCount = 0; satSeen = 1'b0;
    expCur = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 count", int'(tachCount), 0);
    check("R1 valid", int'(countValid), 0);
    check("R1 sat", int'(countSat), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R4 R5: vector table of select, period, expected count
    for (int v = 0; v < NVEC; v++) begin
      int sr;
      sr = (V_SEL[v] > 5) ? 32 : (1 << V_SEL[v]);
      startRun(V_SEL[v], V_EXP[v]);
      runTach(V_PER[v] * TICK_N, 2 * sr + 1, 1'b0);
      repeat (20) @(negedge clk);
      check(V_SEL[v] > 5 ? "R3 strobes" : "R4 strobes", validsSeen, 2);
      check(V_EXP[v] == 2047 ? "R5 latched" : "R2 latched", latchBad, 0);
      check(V_SEL[v] > 5 ? "R3 value" : "R2 value", lastCount, V_EXP[v]);
      if (V_EXP[v] == 2047) check("R6 sat seen", int'(satSeen), 1);
    end

    // R7: narrow spikes inside the low phase are ignored
    startRun(0, 50);
    runTach(50 * TICK_N, 3, 1'b1);
    repeat (20) @(negedge clk);
    check("R7 strobes", validsSeen, 2);
    check("R7 value", lastCount, 50);

    // R8: select change mid-window abandons it
    startRun(2, 30);
    runTach(30 * TICK_N, 3, 1'b0);
    check("R8 no early strobe", validsSeen, 0);
    periodSel = 3'd0;
    runTach(30 * TICK_N, 3, 1'b0);
    repeat (20) @(negedge clk);
    check("R8 strobes", validsSeen, 2);
    check("R8 value", lastCount, 30);
    check("R8 latched", latchBad, 0);

    // R6: silent tach line saturates the running count
    startRun(1, 0);
    repeat (8090) @(negedge clk);
    check("R6 not yet sat", int'(countSat), 0);
    repeat (210) @(negedge clk);
    check("R6 sat", int'(countSat), 1);
    check("R6 no strobe", validsSeen, 0);
    check("R9 count held", int'(tachCount), 30);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule